// File: doc/BRIEF.md
# Conditional Branch Decision Unit

This block keeps the processor's four condition flags (carry, zero, negative, overflow) and, when asked, decides whether a conditional branch is taken. Each instruction that retires presents a flag update together with a tag naming its class. Only arithmetic/logic results, compares and pointer increment/decrement change the flags. Loads, moves and the table-driven shift family do not. A return variant can force the carry flag to a chosen value without touching the others.

A branch names one of eight flag combinations and a polarity bit. The polarity bit turns each combination into its complement, so eight selector codes give sixteen conditions. These cover equal, carry, minus, overflow, signed less-than and signed less-or-equal, their complements, and always/never. Carry follows the no-borrow convention, so after a compare "carry set" means the first operand is unsigned greater-or-equal. Unsigned strictly-higher and lower-or-same have no selector code of their own. The decision is registered and appears one cycle after the evaluate strobe, with a one-cycle valid pulse.

Top module: `bcond_eval`

## Requirements
- R1: After reset all four flags are 0, `taken` is 0 and `taken_vld` is 0. An evaluation right after reset therefore sees Z=C=N=V=0.
- R2: An update with class ALU (1), compare (2) or pointer step (3) loads all four flags from `upd_flags`, whose bit 0 is C, bit 1 Z, bit 2 N and bit 3 V. The new values are seen from the next cycle on.
- R3: Carry uses the no-borrow sense. After a compare of A with B whose flags were formed as C = (A >= B unsigned), selector 1 is taken exactly when A >= B unsigned, and selector 1 with inversion is taken exactly when A < B unsigned.
- R4: Updates with class none/load/move (0), table shift (4) or the reserved codes 6 and 7 leave all four flags unchanged.
- R5: An update with class return-carry (5) sets C to `ret_set` (1 sets, 0 clears) and leaves Z, N and V unchanged.
- R6: The selector picks the flag term as follows: 0 gives Z, 1 gives C, 2 gives N, 3 gives V, 4 gives N xor V (signed less-than), 5 gives (N xor V) or Z (signed less-or-equal), 6 gives constant 1 and 7 gives constant 0.
- R7: When `cond_inv` is 1 the decision is the complement of the selected term. This gives not-equal, carry clear, plus, overflow clear, signed greater-or-equal, signed greater-than, never (6) and always (7).
- R8: When a flag update and an evaluation happen in the same cycle, the evaluation uses the flags held before that update.
- R9: `taken` and `taken_vld` change only on the clock edge that samples `eval_strobe`. `taken_vld` is high for exactly the one cycle after each strobe, and `taken` holds its value while no strobe occurs.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| upd_valid | input | 1 | A retiring instruction presents a flag update |
| upd_class | input | 3 | Instruction class tag of the update |
| upd_flags | input | 4 | Flag result {V,N,Z,C} of the instruction |
| ret_set | input | 1 | Carry value for the return-carry class |
| eval_strobe | input | 1 | Evaluate a branch condition this cycle |
| cond_sel | input | 3 | Flag-combination selector |
| cond_inv | input | 1 | Polarity: complement the selected term |
| taken | output | 1 | Registered branch decision |
| taken_vld | output | 1 | One-cycle pulse marking a new decision |

## Verification
The assertions check on every cycle how the flag register reacts to each class tag. Writer classes load the bus, the return class replaces only carry, and every other class holds the flags. They also check the strobe-to-valid timing and the hold of the decision between strobes. Whether each of the sixteen conditions means the right signed or unsigned comparison can only be shown by the bench scenarios. These drive random compare operands, evaluate every selector and polarity, and compare the decision against comparisons computed directly from the operands. The same applies to the ordering of a same-cycle update and evaluation.

// File: rtl/bcond_pkg.sv
package bcond_pkg;

  localparam int unsigned NUM_TERMS = 8;
  localparam int unsigned SEL_W     = $clog2(NUM_TERMS);
  localparam int unsigned CLASS_W   = 3;

  typedef enum logic [CLASS_W-1:0] {
    CLS_PLAIN = 3'd0,
    CLS_ALU   = 3'd1,
    CLS_CMP   = 3'd2,
    CLS_PSTEP = 3'd3,
    CLS_LUT   = 3'd4,
    CLS_RETC  = 3'd5,
    CLS_RSV6  = 3'd6,
    CLS_RSV7  = 3'd7
  } inst_class_e;

  typedef struct packed {
    logic v;
    logic n;
    logic z;
    logic c;
  } flags_t;

endpackage

// File: rtl/bcond_flag_reg.sv
module bcond_flag_reg
  import bcond_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic               upd_valid,
  input  logic [CLASS_W-1:0] upd_class,
  input  flags_t             upd_flags,
  input  logic               ret_set,
  output flags_t             flags_q
);

  flags_t flags_d;
  logic   wr_all;
  logic   wr_carry;

  always_comb begin
    wr_all   = 1'b0;
    wr_carry = 1'b0;
    if (upd_valid) begin
      unique case (upd_class)
        CLS_ALU, CLS_CMP, CLS_PSTEP: wr_all   = 1'b1;
        CLS_RETC:                    wr_carry = 1'b1;
        default:                     ;
      endcase
    end
  end

  always_comb begin
    flags_d = flags_q;
    if (wr_all) begin
      flags_d = upd_flags;
    end else if (wr_carry) begin
      flags_d.c = ret_set;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_q <= '0;
    end else if (wr_all || wr_carry) begin
      flags_q <= flags_d;
    end
  end

  AST_WRITER_LOADS: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && (upd_class == CLS_ALU || upd_class == CLS_CMP || upd_class == CLS_PSTEP))
    |=> (flags_q == $past(upd_flags))); // R2

  AST_NONWRITER_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (!upd_valid || upd_class == CLS_PLAIN || upd_class == CLS_LUT ||
     upd_class == CLS_RSV6 || upd_class == CLS_RSV7)
    |=> $stable(flags_q)); // R4

  AST_RET_CARRY_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (upd_valid && upd_class == CLS_RETC)
    |=> (flags_q.c == $past(ret_set)) && $stable(flags_q.z) &&
        $stable(flags_q.n) && $stable(flags_q.v)); // R5

endmodule

// File: rtl/bcond_term_mux.sv
module bcond_term_mux
  import bcond_pkg::*;
(
  input  flags_t           flags,
  input  logic [SEL_W-1:0] sel,
  input  logic             inv,
  output logic             result
);

  logic [NUM_TERMS-1:0] terms;
  logic [NUM_TERMS-1:0] hit;
  logic                 picked;

  always_comb begin
    terms    = '0;
    terms[0] = flags.z;
    terms[1] = flags.c;
    terms[2] = flags.n;
    terms[3] = flags.v;
    terms[4] = flags.n ^ flags.v;
    terms[5] = (flags.n ^ flags.v) | flags.z;
    terms[6] = 1'b1;
    terms[7] = 1'b0;
  end

  for (genvar i = 0; i < NUM_TERMS; i++) begin : g_pick
    assign hit[i] = (sel == SEL_W'(i)) & terms[i];
  end

  assign picked = |hit;
  assign result = picked ^ inv;

endmodule

// File: rtl/bcond_eval.sv
module bcond_eval
  import bcond_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       upd_valid,
  input  logic [2:0] upd_class,
  input  logic [3:0] upd_flags,
  input  logic       ret_set,
  input  logic       eval_strobe,
  input  logic [2:0] cond_sel,
  input  logic       cond_inv,
  output logic       taken,
  output logic       taken_vld
);

  flags_t flags_q;
  logic   decision;
  logic   taken_d;
  logic   vld_d;

  bcond_flag_reg u_flags (
    .clk       (clk),
    .rst_n     (rst_n),
    .upd_valid (upd_valid),
    .upd_class (upd_class),
    .upd_flags (flags_t'(upd_flags)),
    .ret_set   (ret_set),
    .flags_q   (flags_q)
  );

  bcond_term_mux u_mux (
    .flags  (flags_q),
    .sel    (cond_sel),
    .inv    (cond_inv),
    .result (decision)
  );

  always_comb begin
    taken_d = taken;
    vld_d   = eval_strobe;
    if (eval_strobe) begin
      taken_d = decision;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      taken     <= 1'b0;
      taken_vld <= 1'b0;
    end else begin
      taken     <= taken_d;
      taken_vld <= vld_d;
    end
  end

  AST_VLD_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    eval_strobe |=> taken_vld); // R9

  AST_HOLD_NO_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    !eval_strobe |=> (!taken_vld && $stable(taken))); // R9

  AST_ALWAYS_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && cond_sel == 3'd6 && !cond_inv) |=> taken); // R6

  AST_NEVER_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    (eval_strobe && cond_sel == 3'd7 && !cond_inv) |=> !taken); // R6

endmodule

// File: tb/tb_bcond_eval.sv
module tb_bcond_eval;

  logic       clk;
  logic       rst_n;
  logic       upd_valid;
  logic [2:0] upd_class;
  logic [3:0] upd_flags;
  logic       ret_set;
  logic       eval_strobe;
  logic [2:0] cond_sel;
  logic       cond_inv;
  logic       taken;
  logic       taken_vld;

  int checks;
  int bad;
  bit exp_q[$];
  string tag_q[$];

  // model flags {V,N,Z,C}
  logic [3:0] mflags;

  bcond_eval dut (
    .clk(clk), .rst_n(rst_n), .upd_valid(upd_valid), .upd_class(upd_class),
    .upd_flags(upd_flags), .ret_set(ret_set), .eval_strobe(eval_strobe),
    .cond_sel(cond_sel), .cond_inv(cond_inv), .taken(taken), .taken_vld(taken_vld)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic check(input string tag, input bit act, input bit exp);
    checks++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  // monitor: pop and compare each decision as it appears
  always @(negedge clk) begin
    if (rst_n && taken_vld) begin
      if (exp_q.size() == 0) begin
        check("R9 unexpected valid", 1'b1, 1'b0);
      end else begin
        bit e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        check(t, taken, e);
      end
    end
  end

  // one cycle of stimulus; eval expectation from flags before this cycle
  task automatic cycle(input bit uv, input logic [2:0] cls, input logic [3:0] fl,
                       input bit rs, input bit ev, input logic [2:0] sel,
                       input bit inv, input bit exp, input string tag);
    @(negedge clk);
    upd_valid = uv; upd_class = cls; upd_flags = fl; ret_set = rs;
    eval_strobe = ev; cond_sel = sel; cond_inv = inv;
    if (ev) begin
      exp_q.push_back(exp);
      tag_q.push_back(tag);
    end
    if (uv) begin
      if (cls == 3'd1 || cls == 3'd2 || cls == 3'd3) mflags = fl;
      else if (cls == 3'd5) mflags[0] = rs;
    end
  endtask

  task automatic idle();
    cycle(1'b0, 3'd0, 4'd0, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
  endtask

  // expected decision computed from the model flags by requirement R6/R7
  function automatic bit flag_cond(input logic [3:0] f, input int sel, input bit inv);
    bit r;
    case (sel)
      0: r = f[1];
      1: r = f[0];
      2: r = f[2];
      3: r = f[3];
      4: r = f[2] != f[3];
      5: r = (f[2] != f[3]) || f[1];
      6: r = 1'b1;
      default: r = 1'b0;
    endcase
    return r ^ inv;
  endfunction

  task automatic eval_flags(input int sel, input bit inv, input string tag);
    cycle(1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 3'(sel), inv, flag_cond(mflags, sel, inv), tag);
  endtask

  // compare A with B, then evaluate all sixteen conditions against direct comparisons
  task automatic compare_all(input logic [15:0] a, input logic [15:0] b);
    logic [15:0] d;
    logic [3:0]  f;
    bit e;
    d = a - b;
    f[0] = (a >= b);
    f[1] = (d == 16'd0);
    f[2] = d[15];
    f[3] = (a[15] != b[15]) && (d[15] != a[15]);
    cycle(1'b1, 3'd2, f, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 8; s++) begin
      for (int p = 0; p < 2; p++) begin
        case (s)
          0: e = (a == b);
          1: e = (a >= b);
          2: e = d[15];
          3: e = f[3];
          4: e = ($signed(a) < $signed(b));
          5: e = ($signed(a) <= $signed(b));
          6: e = 1'b1;
          default: e = 1'b0;
        endcase
        e = e ^ p[0];
        cycle(1'b0, 3'd0, 4'd0, 1'b0, 1'b1, 3'(s), p[0], e,
              (s == 1) ? "R3 no-borrow carry" : (p != 0 ? "R7 inverted condition" : "R6 condition term"));
      end
    end
  endtask

  initial begin
    #1500000;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

  initial begin
    checks = 0; bad = 0;
    mflags = 4'd0;
    upd_valid = 0; upd_class = 0; upd_flags = 0; ret_set = 0;
    eval_strobe = 0; cond_sel = 0; cond_inv = 0;
    rst_n = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    check("R1 reset taken", taken, 1'b0);
    check("R1 reset taken_vld", taken_vld, 1'b0);
    rst_n = 1;
    // R1: flags zero after reset
    eval_flags(0, 1'b0, "R1 zero flag after reset");
    eval_flags(1, 1'b0, "R1 carry after reset");
    eval_flags(4, 1'b1, "R1 signed ge after reset");
    idle();
    idle();
    // R9: taken holds with no strobe, valid low
    check("R9 taken held", taken, 1'b1);
    check("R9 valid low", taken_vld, 1'b0);

    // R2: ALU and pointer-step classes load all flags
    cycle(1'b1, 3'd1, 4'b1010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 4; s++) eval_flags(s, 1'b0, "R2 alu loads flags");
    cycle(1'b1, 3'd3, 4'b0101, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 4; s++) eval_flags(s, 1'b0, "R2 pointer step loads flags");

    // R4: ignored classes
    cycle(1'b1, 3'd0, 4'b1010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    cycle(1'b1, 3'd4, 4'b1010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    cycle(1'b1, 3'd6, 4'b1010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    cycle(1'b1, 3'd7, 4'b1010, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 4; s++) eval_flags(s, 1'b0, "R4 non-writer leaves flags");

    // R5: return-carry set then clear, other flags kept
    cycle(1'b1, 3'd1, 4'b1110, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    cycle(1'b1, 3'd5, 4'b0000, 1'b1, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 4; s++) eval_flags(s, 1'b0, "R5 return sets carry");
    cycle(1'b1, 3'd5, 4'b1111, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    for (int s = 0; s < 4; s++) eval_flags(s, 1'b0, "R5 return clears carry");

    // R8: same-cycle update and evaluate sees old flags (old Z=1 here)
    cycle(1'b1, 3'd1, 4'b0010, 1'b0, 1'b0, 3'd0, 1'b0, 1'b0, "");
    cycle(1'b1, 3'd2, 4'b0000, 1'b0, 1'b1, 3'd0, 1'b0, 1'b1, "R8 old flags in same cycle");
    eval_flags(0, 1'b0, "R8 new flags next cycle");

    // boundary compares, then random
    compare_all(16'h0000, 16'h0000);
    compare_all(16'h8000, 16'h0001);
    compare_all(16'h7FFF, 16'hFFFF);
    compare_all(16'h0001, 16'h0002);
    compare_all(16'hFFFF, 16'h0000);
    for (int i = 0; i < 150; i++) compare_all(16'($urandom), 16'($urandom));

    idle();
    idle();
    if (exp_q.size() != 0) check("R9 missing decisions", 1'b0, 1'b1);
    $display("test done: total=%0d bad=%0d", checks, bad);
    $finish;
  end

endmodule